// File: doc/BRIEF.md
# Operand-Two Barrel Shifter

This block produces the second operand of a data-processing operation together with the shifter carry that a later flag update may use. It takes the low twelve bits of the operation word, a form-select bit, the value of the register to be shifted, the low byte of the register that holds a run-time shift amount, and the current carry flag. It does not read any register file. The caller supplies the register values.

Three forms are covered. In the first, a small constant is rotated right by an even amount. In the second, a register is shifted by a five-bit constant. In the third, a register is shifted by an amount held in a register. The shift kinds are logical left, logical right, arithmetic right, rotate right, and a one-place rotate through the carry flag. Zero-valued constant amounts carry special meanings, listed below. The result can leave the block combinationally or through one register stage, chosen by a parameter.

Top module: `op2_barrel_shifter`

## Requirements
- R1: When `imm_sel` is 1, the result is the zero-extended value `op_field[7:0]`, rotated right by twice `op_field[11:8]`. The rotation is therefore an even amount from 0 to 30.
- R2: In the constant form, carry out equals `carry_in` when `op_field[11:8]` is 0. Otherwise it equals bit 31 of the result.
- R3: When `imm_sel` is 0, `op_field[6:5]` selects the shift kind: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right.
  - `op_field[4]`=0 takes the amount from `op_field[11:7]`.
  - `op_field[4]`=1 takes the amount from `rs_low`.
  - For amounts from 1 to 31, the carry out is the last bit shifted out.
- R4: A constant-amount logical left shift by 0 returns the register value and `carry_in` unchanged.
- R5: A constant-amount logical right or arithmetic right shift whose field is 0 acts as a shift by 32. Logical right gives 0. Arithmetic right gives 32 copies of bit 31. Both give carry equal to the register's bit 31.
- R6: A constant-amount rotate right whose field is 0 is a rotate through carry. The result is {`carry_in`, value[31:1]} and the carry out is value[0].
- R7: A register-amount shift with `rs_low` equal to 0 returns the register value and `carry_in` unchanged, for every kind.
- R8: A register-amount logical shift by exactly 32 gives 0, with carry equal to value[0] for left and value[31] for right. Amounts above 32 give 0 with carry 0.
- R9: A register-amount arithmetic right shift by 32 or more gives all sign bits, with carry equal to value[31].
- R10: A register-amount rotate uses the amount modulo 32. A nonzero multiple of 32 returns the value unchanged, with carry equal to value[31].
- R11: With `REG_OUT`=1, both outputs appear one clock after the inputs, and a synchronous active-high `rst` clears both to 0. With `REG_OUT`=0, the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| op_field | input | 12 | Low twelve bits of the operation word |
| imm_sel | input | 1 | 1 selects the rotated-constant form |
| rm_val | input | DW | Value of the register to be shifted |
| rs_low | input | RAMT_W | Low byte of the shift-amount register |
| carry_in | input | 1 | Current carry flag |
| operand_out | output | DW | Formed second operand |
| carry_out | output | 1 | Shifter carry out |

## Verification
The bench builds two copies at the default 32-bit width: one with `REG_OUT`=1 and one with `REG_OUT`=0. Every stimulus is checked on both copies, so the same-cycle path and the one-cycle registered path are compared against a single reference. The 8-bit amount port allows amounts of exactly 32, just above 32, large values near 200, and rotations past one full turn. This reaches every saturation and modulo case in R8 to R10. The 32-bit width also places the constant-form special cases at their natural encodings.

// File: rtl/op2_pkg.sv
package op2_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/op2_imm_rotator.sv
module op2_imm_rotator #(
  parameter int DW    = 32,
  parameter int IMM_W = 8,
  parameter int ROT_W = 4
) (
  input  logic [IMM_W-1:0] imm_val,
  input  logic [ROT_W-1:0] rot_fld,
  input  logic             carry_in,
  output logic [DW-1:0]    res,
  output logic             cout
);
  localparam int RA_W = ROT_W + 1;

  logic [DW-1:0]   ext;
  logic [2*DW-1:0] dbl;
  logic [RA_W-1:0] rot_amt;

  always_comb begin
    ext     = {{(DW-IMM_W){1'b0}}, imm_val};
    rot_amt = {rot_fld, 1'b0};
    dbl     = {ext, ext} >> rot_amt;
    res     = dbl[DW-1:0];
    cout    = (rot_fld == '0) ? carry_in : dbl[DW-1];
  end
endmodule

// File: rtl/op2_shift_decode.sv
module op2_shift_decode
  import op2_pkg::*;
#(
  parameter int DW     = 32,
  parameter int RAMT_W = 8
) (
  input  logic [11:4]       fld,
  input  logic [RAMT_W-1:0] rs_low,
  output shift_kind_e       kind,
  output logic [RAMT_W-1:0] amt,
  output logic              rrx
);
  logic [4:0] imm5;

  always_comb begin
    kind = shift_kind_e'(fld[6:5]);
    imm5 = fld[11:7];
    rrx  = 1'b0;
    amt  = rs_low;
    if (!fld[4]) begin
      rrx = (imm5 == 5'd0) && (kind == SK_ROR);
      if ((imm5 == 5'd0) && ((kind == SK_LSR) || (kind == SK_ASR)))
        amt = RAMT_W'(DW);
      else
        amt = RAMT_W'(imm5);
    end
  end
endmodule

// File: rtl/op2_shift_core.sv
module op2_shift_core
  import op2_pkg::*;
#(
  parameter int DW     = 32,
  parameter int RAMT_W = 8
) (
  input  logic [DW-1:0]     val,
  input  shift_kind_e       kind,
  input  logic [RAMT_W-1:0] amt,
  input  logic              rrx,
  input  logic              carry_in,
  output logic [DW-1:0]     res,
  output logic              cout
);
  localparam int AMT_W = $clog2(DW);

  logic [2*DW-1:0]        wide_l;
  logic [2*DW-1:0]        wide_r;
  logic signed [2*DW-1:0] wide_a;
  logic [2*DW-1:0]        wide_o;
  logic [RAMT_W-1:0]      amt_sat;
  logic [AMT_W-1:0]       rot_amt;

  always_comb begin
    amt_sat = (amt >= RAMT_W'(DW)) ? RAMT_W'(DW) : amt;
    rot_amt = amt[AMT_W-1:0];
    wide_l  = {{DW{1'b0}}, val} << amt;
    wide_r  = {val, {DW{1'b0}}} >> amt;
    wide_a  = $signed({val, {DW{1'b0}}}) >>> amt_sat;
    wide_o  = {val, val} >> rot_amt;
    res     = val;
    cout    = carry_in;
    if (rrx) begin
      res  = {carry_in, val[DW-1:1]};
      cout = val[0];
    end else if (amt != '0) begin
      unique case (kind)
        SK_LSL: begin res = wide_l[DW-1:0];    cout = wide_l[DW];   end
        SK_LSR: begin res = wide_r[2*DW-1:DW]; cout = wide_r[DW-1]; end
        SK_ASR: begin res = wide_a[2*DW-1:DW]; cout = wide_a[DW-1]; end
        default: begin
          res  = wide_o[DW-1:0];
          cout = wide_o[DW-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/op2_barrel_shifter.sv
module op2_barrel_shifter
  import op2_pkg::*;
#(
  parameter int DW      = 32,
  parameter int IMM_W   = 8,
  parameter int ROT_W   = 4,
  parameter int RAMT_W  = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [11:0]       op_field,
  input  logic              imm_sel,
  input  logic [DW-1:0]     rm_val,
  input  logic [RAMT_W-1:0] rs_low,
  input  logic              carry_in,
  output logic [DW-1:0]     operand_out,
  output logic              carry_out
);
  logic [DW-1:0]     imm_res;
  logic              imm_cy;
  logic [DW-1:0]     sh_res;
  logic              sh_cy;
  shift_kind_e       sh_kind;
  logic [RAMT_W-1:0] sh_amt;
  logic              sh_rrx;
  logic [DW-1:0]     nxt_res;
  logic              nxt_cy;

  op2_imm_rotator #(.DW(DW), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_rot (
    .imm_val (op_field[IMM_W-1:0]),
    .rot_fld (op_field[IMM_W +: ROT_W]),
    .carry_in(carry_in),
    .res     (imm_res),
    .cout    (imm_cy)
  );

  op2_shift_decode #(.DW(DW), .RAMT_W(RAMT_W)) u_dec (
    .fld   (op_field[11:4]),
    .rs_low(rs_low),
    .kind  (sh_kind),
    .amt   (sh_amt),
    .rrx   (sh_rrx)
  );

  op2_shift_core #(.DW(DW), .RAMT_W(RAMT_W)) u_core (
    .val     (rm_val),
    .kind    (sh_kind),
    .amt     (sh_amt),
    .rrx     (sh_rrx),
    .carry_in(carry_in),
    .res     (sh_res),
    .cout    (sh_cy)
  );

  always_comb begin
    nxt_res = imm_sel ? imm_res : sh_res;
    nxt_cy  = imm_sel ? imm_cy  : sh_cy;
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          operand_out <= '0;
          carry_out   <= 1'b0;
        end else begin
          operand_out <= nxt_res;
          carry_out   <= nxt_cy;
        end
      end

      AST_IMM_NOROT: assert property (@(posedge clk) disable iff (rst)
        (imm_sel && op_field[11:8] == 4'd0) |=>
        (operand_out == DW'($past(op_field[7:0])) && carry_out == $past(carry_in))); // R1
      AST_IMM_ROT_CARRY: assert property (@(posedge clk) disable iff (rst)
        (imm_sel && op_field[11:8] != 4'd0) |=> (carry_out == operand_out[DW-1])); // R2
      AST_LSL0_PASS: assert property (@(posedge clk) disable iff (rst)
        (!imm_sel && op_field[11:4] == 8'd0) |=>
        (operand_out == $past(rm_val) && carry_out == $past(carry_in))); // R4
      AST_RRX_FILL: assert property (@(posedge clk) disable iff (rst)
        (!imm_sel && op_field[11:7] == 5'd0 && op_field[6:4] == 3'b110) |=>
        (operand_out[DW-1] == $past(carry_in) && carry_out == $past(rm_val[0]))); // R6
      AST_REG_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
        (!imm_sel && op_field[4] && rs_low == '0) |=>
        (operand_out == $past(rm_val) && carry_out == $past(carry_in))); // R7
      AST_LOGIC_OVER: assert property (@(posedge clk) disable iff (rst)
        (!imm_sel && op_field[4] && !op_field[6] && rs_low > RAMT_W'(DW)) |=>
        (operand_out == '0 && !carry_out)); // R8
      AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (operand_out == '0 && !carry_out)); // R11
    end else begin : g_comb
      assign operand_out = nxt_res;
      assign carry_out   = nxt_cy;
    end
  endgenerate
endmodule

// File: tb/op2_barrel_shifter_tb_top.sv
module op2_barrel_shifter_tb_top;
  localparam int DW = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] op_field = '0;
  logic        imm_sel = 1'b0;
  logic [31:0] rm_val = '0;
  logic [7:0]  rs_low = '0;
  logic        carry_in = 1'b0;
  logic [31:0] op_r, op_c;
  logic        cy_r, cy_c;
  int          n_checks = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  op2_barrel_shifter #(.DW(DW), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .op_field(op_field), .imm_sel(imm_sel),
    .rm_val(rm_val), .rs_low(rs_low), .carry_in(carry_in),
    .operand_out(op_r), .carry_out(cy_r)
  );

  op2_barrel_shifter #(.DW(DW), .REG_OUT(1'b0)) dut_c (
    .clk(clk), .rst(rst), .op_field(op_field), .imm_sel(imm_sel),
    .rm_val(rm_val), .rs_low(rs_low), .carry_in(carry_in),
    .operand_out(op_c), .carry_out(cy_c)
  );

  // Reference: one-bit steps, counted from the requirements.
  function automatic logic [32:0] ref_model(input logic [11:0] f, input logic i,
      input logic [31:0] rm, input logic [7:0] rs, input logic cin);
    logic [31:0] v;
    logic        c;
    int          n;
    v = rm;
    c = cin;
    if (i) begin
      v = {24'd0, f[7:0]};
      n = 2 * int'(f[11:8]);
      for (int k = 0; k < n; k++) v = {v[0], v[31:1]};
      if (n != 0) c = v[31];
      return {c, v};
    end
    n = f[4] ? int'(rs) : int'(f[11:7]);
    if (!f[4] && n == 0) begin
      if (f[6:5] == 2'b01 || f[6:5] == 2'b10) n = 32;
      if (f[6:5] == 2'b11) return {rm[0], cin, rm[31:1]};
    end
    for (int k = 0; k < n; k++) begin
      case (f[6:5])
        2'b00:   begin c = v[31]; v = {v[30:0], 1'b0}; end
        2'b01:   begin c = v[0];  v = {1'b0, v[31:1]}; end
        2'b10:   begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0];  v = {v[0], v[31:1]}; end
      endcase
    end
    return {c, v};
  endfunction

  function automatic logic [11:0] enc_ishf(input logic [4:0] a, input logic [1:0] t);
    return {a, t, 1'b0, 4'h3};
  endfunction

  function automatic logic [11:0] enc_rshf(input logic [1:0] t);
    return {4'h2, 1'b0, t, 1'b1, 4'h5};
  endfunction

  task automatic check(input string tag, input string path,
                       input logic [32:0] act, input logic [32:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual cy=%0b op=%08h expected cy=%0b op=%08h",
               tag, path, act[32], act[31:0], exp[32], exp[31:0]);
    end
  endtask

  task automatic apply(input logic [11:0] f, input logic i, input logic [31:0] rm,
                       input logic [7:0] rs, input logic cin, input string tag);
    logic [32:0] exp;
    exp = ref_model(f, i, rm, rs, cin);
    @(negedge clk);
    op_field = f; imm_sel = i; rm_val = rm; rs_low = rs; carry_in = cin;
    #1;
    check(tag, "comb R11", {cy_c, op_c}, exp);
    @(negedge clk);
    check(tag, "reg R11", {cy_r, op_r}, exp);
  endtask

  task automatic t_reset;
    apply(12'h0ff, 1'b1, 32'h0, 8'h0, 1'b1, "R11 pre-reset");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R11 reset", "reg", {cy_r, op_r}, 33'd0);
    rst = 1'b0;
  endtask

  task automatic t_immediate;
    apply({4'd0, 8'hA5}, 1'b1, 32'hDEAD_BEEF, 8'h0, 1'b1, "R1 R2 rot0 cin1");
    apply({4'd0, 8'h80}, 1'b1, 32'h0, 8'h0, 1'b0, "R2 rot0 cin0");
    apply({4'd1, 8'h03}, 1'b1, 32'h0, 8'h0, 1'b0, "R1 R2 rot2 wrap");
    apply({4'd14, 8'hFE}, 1'b1, 32'h0, 8'h0, 1'b1, "R1 rot28");
    apply({4'd15, 8'hFF}, 1'b1, 32'h0, 8'h0, 1'b1, "R1 rot30");
    apply({4'd4, 8'h7F}, 1'b1, 32'h0, 8'h0, 1'b1, "R2 rot8 top0");
  endtask

  task automatic t_imm_shift;
    apply(enc_ishf(5'd0, 2'b00), 1'b0, 32'h8000_0001, 8'hFF, 1'b1, "R4 lsl0");
    apply(enc_ishf(5'd1, 2'b00), 1'b0, 32'h8000_0001, 8'h0, 1'b0, "R3 lsl1");
    apply(enc_ishf(5'd31, 2'b00), 1'b0, 32'h0000_0003, 8'h0, 1'b0, "R3 lsl31");
    apply(enc_ishf(5'd4, 2'b01), 1'b0, 32'hF000_000F, 8'h0, 1'b0, "R3 lsr4");
    apply(enc_ishf(5'd0, 2'b01), 1'b0, 32'h8000_0000, 8'h0, 1'b0, "R5 lsr32");
    apply(enc_ishf(5'd7, 2'b10), 1'b0, 32'h8000_0040, 8'h0, 1'b0, "R3 asr7");
    apply(enc_ishf(5'd0, 2'b10), 1'b0, 32'h8123_4567, 8'h0, 1'b0, "R5 asr32 neg");
    apply(enc_ishf(5'd0, 2'b10), 1'b0, 32'h7123_4567, 8'h0, 1'b1, "R5 asr32 pos");
    apply(enc_ishf(5'd8, 2'b11), 1'b0, 32'h1234_5680, 8'h0, 1'b0, "R3 ror8");
    apply(enc_ishf(5'd0, 2'b11), 1'b0, 32'h0000_0003, 8'h0, 1'b1, "R6 rrx cin1");
    apply(enc_ishf(5'd0, 2'b11), 1'b0, 32'hFFFF_FFFE, 8'h0, 1'b0, "R6 rrx cin0");
  endtask

  task automatic t_reg_shift;
    for (int t = 0; t < 4; t++) begin
      apply(enc_rshf(2'(t)), 1'b0, 32'hC000_0003, 8'd0, 1'b1, "R7 amt0");
      apply(enc_rshf(2'(t)), 1'b0, 32'hC000_0003, 8'd1, 1'b0, "R3 amt1");
      apply(enc_rshf(2'(t)), 1'b0, 32'hA5A5_5A5A, 8'd31, 1'b0, "R3 amt31");
    end
    apply(enc_rshf(2'b00), 1'b0, 32'h0000_0001, 8'd32, 1'b0, "R8 lsl32");
    apply(enc_rshf(2'b00), 1'b0, 32'hFFFF_FFFF, 8'd33, 1'b1, "R8 lsl33");
    apply(enc_rshf(2'b01), 1'b0, 32'h8000_0000, 8'd32, 1'b0, "R8 lsr32");
    apply(enc_rshf(2'b01), 1'b0, 32'hFFFF_FFFF, 8'd200, 1'b1, "R8 lsr200");
    apply(enc_rshf(2'b10), 1'b0, 32'h8000_0000, 8'd32, 1'b0, "R9 asr32");
    apply(enc_rshf(2'b10), 1'b0, 32'h9000_0000, 8'd255, 1'b0, "R9 asr255");
    apply(enc_rshf(2'b10), 1'b0, 32'h7FFF_FFFF, 8'd40, 1'b1, "R9 asr40 pos");
    apply(enc_rshf(2'b11), 1'b0, 32'h8000_1234, 8'd32, 1'b0, "R10 ror32");
    apply(enc_rshf(2'b11), 1'b0, 32'h0000_1280, 8'd40, 1'b0, "R10 ror40");
    apply(enc_rshf(2'b11), 1'b0, 32'h1234_5678, 8'd224, 1'b1, "R10 ror224");
  endtask

  task automatic t_sweep;
    logic [31:0] s;
    s = 32'h1357_9BDF;
    for (int k = 0; k < 60; k++) begin
      s = s * 32'd1664525 + 32'd1013904223;
      apply(s[31:20], s[3], {s[15:0], s[31:16]} ^ 32'h5A5A_A5A5, s[27:20], s[7], "R3 sweep");
    end
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R11 after reset", "reg", {cy_r, op_r}, 33'd0);
    t_reset;
    t_immediate;
    t_imm_shift;
    t_reg_shift;
    t_sweep;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule